// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Row-Only Refresh

This block connects a simple host request port to an asynchronous DRAM array with 2048 rows and 2048 columns of 4-bit words. Each host access carries a 22-bit word address. The controller splits that address into a row half and a column half and presents them one after the other on a shared 11-bit address bus. A row strobe latches the row and a column strobe latches the column. Writes drive the data bus and the write strobe during the column phase. Reads enable the array's output driver, sample the data a fixed number of cycles after the column strobe falls, and return it on a one-cycle response.

A free-running interval timer raises a refresh request every `REF_INTERVAL` clocks. A pending request is served as soon as the current host access has finished. A refresh cycle drives the next row from a wrapping row counter and pulses only the row strobe. The chip select stays inactive, the column strobe stays high and the data bus is released, so the whole row is restored at once. Host requests are held off while a refresh is pending or running. After every access and every refresh, both strobes stay high for a programmable precharge time.

Top module: `dram_rasref_ctrl`

## Requirements
- R1: The row field is `req_addr[ADDR_W-1:COL_BITS]` and the column field is `req_addr[COL_BITS-1:0]`. On `mem_addr` the row value is present in the cycle `mem_row_stb_n` falls, and the column value is present in the cycle `mem_col_stb_n` falls.
- R2: For a read, `mem_rd_n` is low and `mem_wr_n` is high for the whole column phase. `rsp_valid` pulses for one cycle carrying the `mem_dq_in` value sampled in the last column cycle. The pulse is seen T_RCD+CAS_LAT+1 cycles after the accepting clock edge.
- R3: For a write, `mem_wr_n` is low, `mem_dq_oe` is high and `mem_dq_out` equals the accepted write data throughout the column phase, and at no other time.
- R4: During a refresh, `mem_row_stb_n` is low for exactly T_RAS_REF cycles. Throughout that time `mem_sel_n` stays high, `mem_col_stb_n` stays high and `mem_dq_oe` stays low.
- R5: Refresh rows start at 0 after reset, advance by one per refresh and wrap from the last row back to 0.
- R6: With no host traffic, successive refreshes start exactly REF_INTERVAL cycles apart.
- R7: While a refresh is pending or in progress, `req_ready` is low and no host access starts. A pending refresh wins over a waiting host request.
- R8: Between any two row-strobe pulses, host or refresh, both strobes stay high for at least T_PRE cycles.
- R9: In a host access the row strobe stays low through the whole column phase, and it rises together with the column strobe, so the open row is written back before release.
- R10: After reset, both strobes, `mem_wr_n`, `mem_rd_n` and `mem_sel_n` are high, `mem_dq_oe` and `rsp_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_BITS+COL_BITS | Word address: row in the upper bits, column in the lower bits |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | DATA_W | Read data |
| mem_addr | output | max(ROW_BITS,COL_BITS) | Multiplexed row/column address |
| mem_row_stb_n | output | 1 | Row strobe, active low |
| mem_col_stb_n | output | 1 | Column strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_rd_n | output | 1 | Array output enable, active low |
| mem_sel_n | output | 1 | Chip select, active low, high during refresh |
| mem_dq_out | output | DATA_W | Data driven toward the array |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | DATA_W | Data returned by the array |

## Verification
The read response is due exactly T_RCD+CAS_LAT+1 falling edges after the edge that accepts the request. The bench counts those edges from the acceptance and compares the count with that sum. Strobe, address and data-bus behaviour is due in the same cycle as the strobe edge it belongs to. A negedge monitor therefore compares the pins in the cycle it first sees each strobe fall or rise, and it also checks the length of each refresh pulse and each precharge gap. Refresh spacing is checked only in an idle window, where each start must come exactly REF_INTERVAL cycles after the one before. A bench-side array model makes the full write-then-read sweep over a small 8x8 configuration check the data end to end.

// File: rtl/dram_rasref_pkg.sv
package dram_rasref_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ROW  = 3'd1,
    ST_COL  = 3'd2,
    ST_PRE  = 3'd3,
    ST_REF  = 3'd4
  } seq_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int REF_INTERVAL = 1000,
  parameter int ROW_BITS     = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ref_take,
  input  logic                ref_done,
  output logic                ref_pend,
  output logic [ROW_BITS-1:0] ref_row
);
  localparam int IW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;

  logic [IW-1:0] tick_cnt;
  logic          tick_wrap;

  assign tick_wrap = (tick_cnt == IW'(REF_INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      ref_pend <= 1'b0;
      ref_row  <= '0;
    end else begin
      tick_cnt <= tick_wrap ? '0 : tick_cnt + 1'b1;
      if (tick_wrap)
        ref_pend <= 1'b1;
      else if (ref_take)
        ref_pend <= 1'b0;
      if (ref_done)
        ref_row <= ref_row + 1'b1;
    end
  end

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> (ref_row == $past(ref_row) + 1'b1)); // R5
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pend && !ref_take) |=> ref_pend); // R6
endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq
  import dram_rasref_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 4,
  parameter int T_RCD     = 2,
  parameter int CAS_LAT   = 2,
  parameter int T_PRE     = 2,
  parameter int T_RAS_REF = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              ref_pend,
  output logic              ref_take,
  output logic              ref_done,
  input  logic [DATA_W-1:0] mem_dq_in,
  output seq_state_t        state,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [DATA_W-1:0] lat_wdata,
  output logic              lat_write,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int TMAX = max2(max2(T_RCD, CAS_LAT), max2(T_PRE, T_RAS_REF));
  localparam int CW   = $clog2(TMAX + 1);

  logic [CW-1:0] cnt;
  logic          cnt_zero;
  logic          acc_accept;
  logic          col_last;

  function automatic logic [CW-1:0] load_of(input int cycles);
    return CW'(cycles - 1);
  endfunction

  assign cnt_zero   = (cnt == '0);
  assign req_ready  = (state == ST_IDLE) && !ref_pend;
  assign ref_take   = (state == ST_IDLE) && ref_pend;
  assign ref_done   = (state == ST_REF) && cnt_zero;
  assign acc_accept = req_valid && req_ready;
  assign col_last   = (state == ST_COL) && cnt_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_write <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (ref_take) begin
            state <= ST_REF;
            cnt   <= load_of(T_RAS_REF);
          end else if (acc_accept) begin
            state     <= ST_ROW;
            cnt       <= load_of(T_RCD);
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            lat_write <= req_write;
          end
        end
        ST_ROW: begin
          if (cnt_zero) begin
            state <= ST_COL;
            cnt   <= load_of(CAS_LAT);
          end else cnt <= cnt - 1'b1;
        end
        ST_COL: begin
          if (col_last) begin
            if (!lat_write) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= mem_dq_in;
            end
            state <= ST_PRE;
            cnt   <= load_of(T_PRE);
          end else cnt <= cnt - 1'b1;
        end
        ST_PRE: begin
          if (cnt_zero) state <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        ST_REF: begin
          if (cnt_zero) begin
            state <= ST_PRE;
            cnt   <= load_of(T_PRE);
          end else cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(state) == ST_COL && !lat_write)); // R2
  AST_REF_BEFORE_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && ref_pend) |=> (state == ST_REF)); // R7
  AST_NO_ACCEPT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pend && state == ST_IDLE) |=> (state != ST_ROW)); // R7
endmodule

// File: rtl/dram_pin_drive.sv
module dram_pin_drive
  import dram_rasref_pkg::*;
#(
  parameter int ROW_BITS = 11,
  parameter int COL_BITS = 11,
  parameter int DATA_W   = 4,
  parameter int T_PRE    = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  seq_state_t                   state,
  input  logic [ROW_BITS+COL_BITS-1:0] lat_addr,
  input  logic [DATA_W-1:0]            lat_wdata,
  input  logic                         lat_write,
  input  logic [ROW_BITS-1:0]          ref_row,
  output logic [max2(ROW_BITS,COL_BITS)-1:0] mem_addr,
  output logic                         mem_row_stb_n,
  output logic                         mem_col_stb_n,
  output logic                         mem_wr_n,
  output logic                         mem_rd_n,
  output logic                         mem_sel_n,
  output logic [DATA_W-1:0]            mem_dq_out,
  output logic                         mem_dq_oe
);
  localparam int ADDR_W = ROW_BITS + COL_BITS;
  localparam int MUX_W  = max2(ROW_BITS, COL_BITS);
  localparam int GW     = $clog2(T_PRE + 2);

  function automatic logic [MUX_W-1:0] row_field(input logic [ADDR_W-1:0] a);
    return MUX_W'(a[ADDR_W-1:COL_BITS]);
  endfunction

  function automatic logic [MUX_W-1:0] col_field(input logic [ADDR_W-1:0] a);
    return MUX_W'(a[COL_BITS-1:0]);
  endfunction

  always_comb begin
    mem_addr      = '0;
    mem_row_stb_n = 1'b1;
    mem_col_stb_n = 1'b1;
    mem_wr_n      = 1'b1;
    mem_rd_n      = 1'b1;
    mem_sel_n     = 1'b1;
    mem_dq_out    = '0;
    mem_dq_oe     = 1'b0;
    unique case (state)
      ST_ROW: begin
        mem_addr      = row_field(lat_addr);
        mem_row_stb_n = 1'b0;
        mem_sel_n     = 1'b0;
      end
      ST_COL: begin
        mem_addr      = col_field(lat_addr);
        mem_row_stb_n = 1'b0;
        mem_col_stb_n = 1'b0;
        mem_sel_n     = 1'b0;
        if (lat_write) begin
          mem_wr_n   = 1'b0;
          mem_dq_out = lat_wdata;
          mem_dq_oe  = 1'b1;
        end else begin
          mem_rd_n = 1'b0;
        end
      end
      ST_REF: begin
        mem_addr      = MUX_W'(ref_row);
        mem_row_stb_n = 1'b0;
      end
      default: ;
    endcase
  end

  logic [GW-1:0] gap_cnt;
  logic          seen_pulse;
  logic          both_high;

  assign both_high = mem_row_stb_n && mem_col_stb_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt    <= '0;
      seen_pulse <= 1'b0;
    end else begin
      if (!mem_row_stb_n) begin
        gap_cnt    <= '0;
        seen_pulse <= 1'b1;
      end else if (both_high && gap_cnt != GW'(T_PRE + 1)) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  AST_PRECHARGE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_pulse && mem_row_stb_n && state == ST_IDLE) |=> (mem_row_stb_n || gap_cnt >= GW'(T_PRE))); // R8
  AST_COL_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_col_stb_n |-> !mem_row_stb_n); // R9
  AST_REF_ROW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_row_stb_n && mem_sel_n) |-> (mem_col_stb_n && !mem_dq_oe && mem_wr_n && mem_rd_n)); // R4
  AST_WR_IN_COL: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> (mem_dq_oe && !mem_col_stb_n && mem_rd_n)); // R3
endmodule

// File: rtl/dram_rasref_ctrl.sv
module dram_rasref_ctrl
  import dram_rasref_pkg::*;
#(
  parameter int ROW_BITS     = 11,
  parameter int COL_BITS     = 11,
  parameter int DATA_W       = 4,
  parameter int REF_INTERVAL = 1000,
  parameter int T_RCD        = 2,
  parameter int CAS_LAT      = 2,
  parameter int T_PRE        = 2,
  parameter int T_RAS_REF    = 3,
  localparam int ADDR_W      = ROW_BITS + COL_BITS,
  localparam int MUX_W       = max2(ROW_BITS, COL_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [MUX_W-1:0]  mem_addr,
  output logic              mem_row_stb_n,
  output logic              mem_col_stb_n,
  output logic              mem_wr_n,
  output logic              mem_rd_n,
  output logic              mem_sel_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  seq_state_t          state;
  logic                ref_pend;
  logic                ref_take;
  logic                ref_done;
  logic [ROW_BITS-1:0] ref_row;
  logic [ADDR_W-1:0]   lat_addr;
  logic [DATA_W-1:0]   lat_wdata;
  logic                lat_write;
  logic                refresh_on_pins;

  dram_refresh_timer #(
    .REF_INTERVAL(REF_INTERVAL),
    .ROW_BITS    (ROW_BITS)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_take(ref_take),
    .ref_done(ref_done),
    .ref_pend(ref_pend),
    .ref_row (ref_row)
  );

  dram_access_seq #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .T_RCD    (T_RCD),
    .CAS_LAT  (CAS_LAT),
    .T_PRE    (T_PRE),
    .T_RAS_REF(T_RAS_REF)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_ready(req_ready),
    .ref_pend (ref_pend),
    .ref_take (ref_take),
    .ref_done (ref_done),
    .mem_dq_in(mem_dq_in),
    .state    (state),
    .lat_addr (lat_addr),
    .lat_wdata(lat_wdata),
    .lat_write(lat_write),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  dram_pin_drive #(
    .ROW_BITS(ROW_BITS),
    .COL_BITS(COL_BITS),
    .DATA_W  (DATA_W),
    .T_PRE   (T_PRE)
  ) u_pins (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state),
    .lat_addr     (lat_addr),
    .lat_wdata    (lat_wdata),
    .lat_write    (lat_write),
    .ref_row      (ref_row),
    .mem_addr     (mem_addr),
    .mem_row_stb_n(mem_row_stb_n),
    .mem_col_stb_n(mem_col_stb_n),
    .mem_wr_n     (mem_wr_n),
    .mem_rd_n     (mem_rd_n),
    .mem_sel_n    (mem_sel_n),
    .mem_dq_out   (mem_dq_out),
    .mem_dq_oe    (mem_dq_oe)
  );

  assign refresh_on_pins = !mem_row_stb_n && mem_sel_n;

  AST_READY_LOW_IN_REF: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_on_pins |-> !req_ready); // R7
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R2
endmodule

// File: tb/dram_rasref_ctrl_test.sv
module dram_rasref_ctrl_test;
  localparam int RB = 3, CB = 3, DW = 4;
  localparam int INTV = 40, TRCD = 2, CL = 2, TPRE = 2, TREF = 3;
  localparam int AW = RB + CB, ROWS = 1 << RB, WORDS = 1 << AW;
  localparam int RD_LAT = TRCD + CL + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [2:0] mem_addr;
  logic mem_row_stb_n, mem_col_stb_n, mem_wr_n, mem_rd_n, mem_sel_n, mem_dq_oe;

  always #10 clk = ~clk;

  dram_rasref_ctrl #(.ROW_BITS(RB), .COL_BITS(CB), .DATA_W(DW), .REF_INTERVAL(INTV),
    .T_RCD(TRCD), .CAS_LAT(CL), .T_PRE(TPRE), .T_RAS_REF(TREF)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_row_stb_n(mem_row_stb_n), .mem_col_stb_n(mem_col_stb_n),
    .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n), .mem_sel_n(mem_sel_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  int errors = 0, checks = 0;
  bit done = 1'b0, mon_on = 1'b0, idle_phase = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Array model
  logic [DW-1:0] arr [WORDS];
  logic [RB-1:0] m_row = '0;
  logic [CB-1:0] m_col = '0;
  assign mem_dq_in = arr[{m_row, m_col}];

  function automatic logic [DW-1:0] pattern(input int a);
    return DW'((a * 5 + 3) % 16);
  endfunction

  // Monitor
  int cyc = 0, gap = 0, ref_len = 0, last_ref = -1, exp_ref = 0;
  bit in_ref = 1'b0, seen = 1'b0, prev_row = 1'b1, prev_col = 1'b1;
  logic [AW-1:0] mon_addr = '0;
  logic [DW-1:0] mon_data = '0;
  bit mon_write = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      cyc++;
      if (prev_row && !mem_row_stb_n) begin
        if (seen) check(gap >= TPRE, "R8 precharge gap", gap, TPRE);
        seen = 1'b1;
        if (mem_sel_n) begin
          check(int'(mem_addr) == exp_ref, "R5 refresh row", int'(mem_addr), exp_ref);
          exp_ref = (exp_ref + 1) % ROWS;
          if (idle_phase && last_ref >= 0)
            check(cyc - last_ref == INTV, "R6 refresh spacing", cyc - last_ref, INTV);
          last_ref = cyc;
          in_ref = 1'b1;
          ref_len = 0;
        end else begin
          check(int'(mem_addr) == int'(mon_addr >> CB), "R1 row address", int'(mem_addr), int'(mon_addr >> CB));
          m_row = mem_addr[RB-1:0];
        end
      end
      if (!mem_row_stb_n && mem_sel_n) begin
        ref_len++;
        check(mem_col_stb_n && !mem_dq_oe && !req_ready, "R4 R7 refresh isolation",
              {mem_col_stb_n, mem_dq_oe, req_ready}, 3'b100);
      end
      if (!prev_row && mem_row_stb_n && in_ref) begin
        check(ref_len == TREF, "R4 refresh pulse length", ref_len, TREF);
        in_ref = 1'b0;
      end
      if (prev_col && !mem_col_stb_n) begin
        check(int'(mem_addr) == int'(mon_addr % (1 << CB)), "R1 column address",
              int'(mem_addr), int'(mon_addr % (1 << CB)));
        m_col = mem_addr[CB-1:0];
      end
      if (!mem_col_stb_n) begin
        if (mon_write) begin
          check(!mem_wr_n && mem_rd_n && mem_dq_oe && mem_dq_out == mon_data, "R3 write phase",
                int'(mem_dq_out), int'(mon_data));
          arr[{m_row, m_col}] = mem_dq_out;
        end else begin
          check(!mem_rd_n && mem_wr_n && !mem_dq_oe, "R2 read phase",
                {mem_rd_n, mem_wr_n, mem_dq_oe}, 3'b010);
        end
      end else begin
        if (!mem_wr_n || mem_dq_oe) check(1'b0, "R3 write outside column phase", 1, 0);
      end
      if (!prev_col && mem_col_stb_n)
        check(mem_row_stb_n, "R9 row released with column", mem_row_stb_n, 1);
      if (mem_row_stb_n && mem_col_stb_n) gap++;
      else gap = 0;
      if (req_valid && req_ready) begin
        mon_addr = req_addr;
        mon_write = req_write;
        mon_data = req_wdata;
      end
      prev_row = mem_row_stb_n;
      prev_col = mem_col_stb_n;
    end
  end

  task automatic access(input bit wr, input int a, input logic [DW-1:0] d);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!wr) begin
      n = 1;
      while (!rsp_valid && n < 50) begin
        @(negedge clk);
        n++;
      end
      check(n == RD_LAT, "R2 read latency", n, RD_LAT);
      check(rsp_rdata == pattern(a), "R2 read data", int'(rsp_rdata), int'(pattern(a)));
    end
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) arr[i] = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_row_stb_n && mem_col_stb_n && mem_wr_n && mem_rd_n && mem_sel_n &&
          !mem_dq_oe && !rsp_valid && req_ready, "R10 reset state", 0, 1);
    mon_on = 1'b1;
    cyc = 1;
    idle_phase = 1'b1;
    repeat (6 * INTV) @(negedge clk);
    idle_phase = 1'b0;
    for (int a = 0; a < WORDS; a++) access(1'b1, a, pattern(a));
    for (int a = WORDS - 1; a >= 0; a--) access(1'b0, a, 'x);
    for (int a = 0; a < WORDS; a += 3) access(1'b0, a, 'x);
    repeat (20) @(negedge clk);
    check(exp_ref > 0 || last_ref > 0, "R5 refreshes seen", last_ref, 1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule